// File: doc/BRIEF.md
# Clip and Requantize Stage for a Converter Feed

This block sits between a parallel inverse-transform datapath and a narrow digital-to-analog converter. Each clock it takes a beat of several real samples, one per lane, each a signed word of the transform's arithmetic width. It limits every sample to a symmetric window set by a threshold, then multiplies the limited value by a fixed-point gain and rounds the result into a short signed converter code. The output resolution is a parameter of its own and does not follow the arithmetic width. A single flag per beat tells downstream logic that at least one lane hit the limit.

The threshold and gain come from run-time inputs, but the block only adopts new values on a beat that opens a frame (valid and start-of-frame both high). Inside a frame the settings are frozen, so a frame never mixes two scalings. Software picks the gain to map the threshold near full scale of the converter word. The datapath is a two-stage pipeline, and the valid bit travels with the data.

Top module: `clip_requant`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, out_clip and out_data are cleared at that edge. The active threshold returns to 2^(IN_W-1)-1 and the active gain to 1.0 (2^GAIN_FRAC).
- R2: A beat presented with in_valid high in cycle c appears with out_valid high in cycle c+2. A cycle with in_valid low gives out_valid low two cycles later.
- R3: With active threshold T, a sample x above T is limited to T, a sample below -T is limited to -T, and any other sample passes unchanged.
- R4: out_clip is high on an output beat exactly when some lane of that beat had |x| > T. A sample with |x| equal to T does not raise it. out_clip is never high without out_valid.
- R5: The output code for a limited sample c is sign(c) * floor((|c| * G + 2^(GAIN_FRAC-1)) / 2^GAIN_FRAC), where G is the unsigned gain with GAIN_FRAC fraction bits. Exact halves therefore round away from zero.
- R6: Codes are saturated to the range -(2^(OUT_W-1)-1) to +(2^(OUT_W-1)-1). The code -2^(OUT_W-1) is never produced.
- R7: cfg_thresh and cfg_gain are loaded only on a beat with in_valid and in_sof both high, and that beat already uses the new values. Changes on other beats have no effect on the output.
- R8: in_sof high while in_valid is low loads nothing.
- R9: Lane i takes its input from in_data[i*IN_W +: IN_W] and drives out_data[i*OUT_W +: OUT_W], both two's complement. Lanes are processed independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | Beat opens a frame; settings load here |
| in_data | input | LANES*IN_W | Signed input samples, lane 0 in the low bits |
| cfg_thresh | input | IN_W-1 | Requested clipping threshold (magnitude) |
| cfg_gain | input | GAIN_W | Requested gain, GAIN_FRAC fraction bits |
| out_valid | output | 1 | Output beat valid |
| out_data | output | LANES*OUT_W | Signed converter codes, lane 0 in the low bits |
| out_clip | output | 1 | Some lane of this beat was limited |

## Verification
The bench builds the block with two lanes, an 8-bit input, a 4-bit output, and an 8-bit gain with 6 fraction bits. The 4-bit code saturates at plus or minus 7, so moderate gains already reach saturation. The 8-bit input lets the bench drive the most negative sample (-128) against the full-range reset threshold of 127. With 6 fraction bits and a gain of 9, a sample of 32 lands on an exact half (4.5), which exercises the rounding rule in both signs. Settings are changed mid-frame, on a start-of-frame beat, and with start-of-frame on an idle cycle, and the output shows which values were in force each time.

// File: rtl/cr_pkg.sv
// Shared helpers for the clip and requantize stage.
// Assumes widths of at least 2 bits wherever a peak code is asked for.
package cr_pkg;

    // Largest positive code a signed word of the given width holds symmetrically.
    function automatic int unsigned peak_code(input int unsigned width);
        return (32'd1 << (width - 1)) - 32'd1;
    endfunction

endpackage

// File: rtl/cr_cfg_shadow.sv
// Holds the threshold and gain in force for the current frame.
// New values are taken only when load is high, and they apply to that beat too.
// Assumes GAIN_FRAC < GAIN_W so that a gain of 1.0 is representable.
module cr_cfg_shadow #(
    parameter int THR_W     = 11,
    parameter int GAIN_W    = 10,
    parameter int GAIN_FRAC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [THR_W-1:0]  cfg_thr,
    input  logic [GAIN_W-1:0] cfg_gain,
    output logic [THR_W-1:0]  eff_thr,
    output logic [GAIN_W-1:0] eff_gain
);
    localparam logic [THR_W-1:0]  THR_RST  = '1;
    localparam logic [GAIN_W-1:0] GAIN_RST = {{(GAIN_W-1){1'b0}}, 1'b1} << GAIN_FRAC;

    logic [THR_W-1:0]  act_thr;
    logic [GAIN_W-1:0] act_gain;

    // Pick the settings for this beat: fresh ones on a frame start, else held.
    always_comb begin
        eff_thr  = load ? cfg_thr  : act_thr;
        eff_gain = load ? cfg_gain : act_gain;
    end

    // Capture requested settings at a frame start, restore defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_thr  <= THR_RST;
            act_gain <= GAIN_RST;
        end else if (load) begin
            act_thr  <= cfg_thr;
            act_gain <= cfg_gain;
        end
    end

    // R7
    hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load)) |-> ($stable(act_thr) && $stable(act_gain)));

endmodule

// File: rtl/cr_lane_clip.sv
// First pipeline stage of one lane: limits a signed sample to +/- thr and
// registers it as sign and magnitude, plus a flag when limiting happened.
// Assumes thr is an unsigned magnitude one bit narrower than the sample.
module cr_lane_clip #(
    parameter int IN_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IN_W-1:0] x,
    input  logic [IN_W-2:0] thr,
    output logic            neg,
    output logic [IN_W-2:0] mag,
    output logic            over
);
    logic            x_neg;
    logic [IN_W-1:0] abs_x;
    logic            over_c;

    // Take the magnitude of the sample and compare it with the threshold.
    always_comb begin
        x_neg  = x[IN_W-1];
        abs_x  = x_neg ? (~x + 1'b1) : x;
        over_c = abs_x > {1'b0, thr};
    end

    // Register the limited magnitude, its sign and the limit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            neg  <= 1'b0;
            mag  <= '0;
            over <= 1'b0;
        end else begin
            neg  <= x_neg;
            mag  <= over_c ? thr : abs_x[IN_W-2:0];
            over <= over_c;
        end
    end

    // R3
    mag_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mag <= $past(thr)));

    // R4
    clip_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        over |-> (mag == $past(thr)));

endmodule

// File: rtl/cr_lane_scale.sv
// Second pipeline stage of one lane: multiplies the limited magnitude by the
// gain, rounds half away from zero, saturates to the symmetric code range and
// restores the sign. Assumes GAIN_FRAC >= 1 and IN_W + GAIN_W > OUT_W.
module cr_lane_scale #(
    parameter int IN_W      = 12,
    parameter int GAIN_W    = 10,
    parameter int GAIN_FRAC = 8,
    parameter int OUT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             neg,
    input  logic [IN_W-2:0]  mag,
    input  logic [GAIN_W-1:0] gain,
    output logic [OUT_W-1:0] y
);
    localparam int MAG_W  = IN_W - 1;
    localparam int PROD_W = MAG_W + GAIN_W + 1;
    localparam int PEAK   = int'(cr_pkg::peak_code(OUT_W));
    localparam logic [PROD_W-1:0] HALF     = {{(PROD_W-1){1'b0}}, 1'b1} << (GAIN_FRAC - 1);
    localparam logic [PROD_W-1:0] PEAK_P   = PROD_W'(PEAK);
    localparam logic [OUT_W-1:0]  MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] rnd;
    logic [OUT_W-2:0]  lvl;
    logic [OUT_W-1:0]  pos;
    logic [OUT_W-1:0]  y_d;

    // Scale, round, clamp and sign the magnitude into a converter code.
    always_comb begin
        prod = PROD_W'(mag) * PROD_W'(gain) + HALF;
        rnd  = prod >> GAIN_FRAC;
        lvl  = (rnd > PEAK_P) ? PEAK_P[OUT_W-2:0] : rnd[OUT_W-2:0];
        pos  = {1'b0, lvl};
        y_d  = neg ? (~pos + 1'b1) : pos;
    end

    // Register the code.
    always_ff @(posedge clk) begin
        if (!rst_n) y <= '0;
        else        y <= y_d;
    end

    // R6
    no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y != MIN_CODE);

endmodule

// File: rtl/clip_requant.sv
// Clip and requantize stage: LANES signed samples per beat are limited to a
// frame-wide threshold, scaled by a frame-wide gain and rounded to OUT_W-bit
// converter codes. Latency is two cycles, and valid travels with the data.
// Settings load on a beat with in_valid and in_sof both high.
module clip_requant #(
    parameter int LANES     = 4,
    parameter int IN_W      = 12,
    parameter int OUT_W     = 6,
    parameter int GAIN_W    = 10,
    parameter int GAIN_FRAC = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_sof,
    input  logic [LANES*IN_W-1:0]  in_data,
    input  logic [IN_W-2:0]        cfg_thresh,
    input  logic [GAIN_W-1:0]      cfg_gain,
    output logic                   out_valid,
    output logic [LANES*OUT_W-1:0] out_data,
    output logic                   out_clip
);
    localparam int THR_W = IN_W - 1;

    logic              load;
    logic [THR_W-1:0]  eff_thr;
    logic [GAIN_W-1:0] eff_gain;
    logic              v1;
    logic [GAIN_W-1:0] g1;
    logic [LANES-1:0]  s1_neg;
    logic [LANES-1:0]  s1_over;
    logic [THR_W-1:0]  s1_mag [LANES];

    // A frame start needs both valid and start-of-frame.
    assign load = in_valid & in_sof;

    cr_cfg_shadow #(
        .THR_W     (THR_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .cfg_thr  (cfg_thresh),
        .cfg_gain (cfg_gain),
        .eff_thr  (eff_thr),
        .eff_gain (eff_gain)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        cr_lane_clip #(
            .IN_W (IN_W)
        ) u_clip (
            .clk   (clk),
            .rst_n (rst_n),
            .x     (in_data[i*IN_W +: IN_W]),
            .thr   (eff_thr),
            .neg   (s1_neg[i]),
            .mag   (s1_mag[i]),
            .over  (s1_over[i])
        );

        cr_lane_scale #(
            .IN_W      (IN_W),
            .GAIN_W    (GAIN_W),
            .GAIN_FRAC (GAIN_FRAC),
            .OUT_W     (OUT_W)
        ) u_scale (
            .clk   (clk),
            .rst_n (rst_n),
            .neg   (s1_neg[i]),
            .mag   (s1_mag[i]),
            .gain  (g1),
            .y     (out_data[i*OUT_W +: OUT_W])
        );
    end

    // Stage 1 side band: valid and the gain that belongs to the beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            g1 <= '0;
        end else begin
            v1 <= in_valid;
            g1 <= eff_gain;
        end
    end

    // Stage 2 side band: output valid and the beat-wide limit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_clip  <= 1'b0;
        end else begin
            out_valid <= v1;
            out_clip  <= v1 & (|s1_over);
        end
    end

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n, 1) && $past(rst_n, 2)) |-> (out_valid == $past(in_valid, 2)));

    // R4
    clip_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_clip |-> out_valid);

endmodule

// File: tb/tb_clip_requant.sv
module tb_clip_requant;
    localparam int LANES = 2;
    localparam int IN_W  = 8;
    localparam int OUT_W = 4;
    localparam int GW    = 8;
    localparam int GF    = 6;
    localparam int NV    = 8;

    // Table: lane inputs, expected codes, expected flag (T=50, G=9, first beat opens frame)
    localparam int VX0 [NV] = '{0, -10, 50, 51, -128, 32, 7, -51};
    localparam int VX1 [NV] = '{10, 25, -50, 3, 127, -32, -3, 0};
    localparam int VE0 [NV] = '{0, -1, 7, 7, -7, 5, 1, -7};
    localparam int VE1 [NV] = '{1, 4, -7, 0, 7, -5, 0, 0};
    localparam int VEC [NV] = '{0, 0, 0, 1, 1, 0, 0, 1};

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic                   in_sof = 1'b0;
    logic [LANES*IN_W-1:0]  in_data = '0;
    logic [IN_W-2:0]        cfg_thresh = '0;
    logic [GW-1:0]          cfg_gain = '0;
    logic                   out_valid;
    logic [LANES*OUT_W-1:0] out_data;
    logic                   out_clip;

    int checks = 0;
    int failures = 0;

    clip_requant #(
        .LANES(LANES), .IN_W(IN_W), .OUT_W(OUT_W), .GAIN_W(GW), .GAIN_FRAC(GF)
    ) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_data(in_data), .cfg_thresh(cfg_thresh), .cfg_gain(cfg_gain),
        .out_valid(out_valid), .out_data(out_data), .out_clip(out_clip)
    );

    always #10 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int lane(int i);
        return int'($signed(out_data[i*OUT_W +: OUT_W]));
    endfunction

    task automatic drive(int a, int b, bit sof);
        in_data  = {IN_W'(b), IN_W'(a)};
        in_valid = 1'b1;
        in_sof   = sof;
    endtask

    task automatic check_out(string tag, int ea, int eb, int ec);
        chk({tag, " valid"}, int'(out_valid), 1);
        chk({tag, " lane0"}, lane(0), ea);
        chk({tag, " lane1"}, lane(1), eb);
        chk({tag, " clip"}, int'(out_clip), ec);
    endtask

    // One isolated beat, checked two cycles later
    task automatic beat(int a, int b, bit sof, int ea, int eb, int ec, string tag);
        @(negedge clk);
        drive(a, b, sof);
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        @(negedge clk);
        check_out(tag, ea, eb, ec);
    endtask

    task automatic finish_up();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset valid", int'(out_valid), 0);
        chk("R1 reset data", int'(out_data), 0);
        chk("R1 reset clip", int'(out_clip), 0);

        // R1: defaults T=127, G=1.0 in force; requested values not loaded without sof
        cfg_thresh = 7'd10;
        cfg_gain   = 8'd9;
        beat(3, -5, 1'b0, 3, -5, 0, "R1 default gain");
        beat(-128, 100, 1'b0, -7, 7, 1, "R1 default thresh R6");

        // Table walk, streamed back to back (R3 R4 R5 R9)
        cfg_thresh = 7'd50;
        cfg_gain   = 8'd9;
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) check_out($sformatf("R5 R3 R9 vec%0d", i - 2),
                                  VE0[i-2], VE1[i-2], VEC[i-2]);
            if (i < NV) drive(VX0[i], VX1[i], i == 0);
            else begin
                in_valid = 1'b0;
                in_sof   = 1'b0;
            end
        end

        // R7: threshold change mid-frame ignored, then applied on sof beat itself
        cfg_thresh = 7'd20;
        beat(40, 0, 1'b0, 6, 0, 0, "R7 mid-frame thresh");
        beat(40, -40, 1'b1, 3, -3, 1, "R7 sof thresh");
        cfg_thresh = 7'd127;
        cfg_gain   = 8'd255;
        beat(1, 0, 1'b0, 0, 0, 0, "R7 mid-frame gain");

        // R8: sof on an idle cycle loads nothing
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b1;
        @(negedge clk);
        in_sof = 1'b0;
        beat(30, 0, 1'b0, 3, 0, 1, "R8 idle sof");

        // R6: saturation with the large gain
        beat(2, -2, 1'b1, 7, -7, 0, "R6 saturate");
        beat(1, -1, 1'b0, 4, -4, 0, "R5 R6 below peak");

        // R2: exact latency
        @(negedge clk);
        drive(5, 0, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 one cycle", int'(out_valid), 0);
        @(negedge clk);
        chk("R2 two cycles", int'(out_valid), 1);
        chk("R2 data", lane(0), 7);
        @(negedge clk);
        chk("R2 drop", int'(out_valid), 0);

        // R1: reset in the middle of a stream
        @(negedge clk);
        drive(5, 5, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset valid", int'(out_valid), 0);
        chk("R1 mid reset data", int'(out_data), 0);
        chk("R1 mid reset clip", int'(out_clip), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        beat(-128, 3, 1'b0, -7, 3, 1, "R1 defaults after reset");

        finish_up();
    end
endmodule